// File: doc/BRIEF.md
# TRS Flag Inserter

This block sits on a 10-bit parallel video word stream clocked by the pixel clock. It finds each timing reference sequence (TRS) in the stream. This covers both end-of-active-video (EAV) and start-of-active-video (SAV) sequences. For each one it rebuilds the fourth word, the XYZ status word, from field, vertical-blanking and horizontal-blanking timing inputs supplied by the surrounding system. The new flag bits therefore reflect the system's own timing and not whatever arrived in the stream.

A TRS is recognised as the words 3FF, 000, 000 followed by the XYZ word. Insertion happens only when the block is told to use external flags and processing is enabled. Otherwise every word, including the XYZ word, passes through unchanged. Two conventions are supported for the horizontal input. In the first, the EAV/SAV identity of the received word decides the H bit. In the second, the horizontal input is copied directly. Every word leaves the block after a fixed delay of four clock cycles, and a one-cycle marker travels alongside each XYZ word.

Top module: `trs_flag_inserter`

## Requirements
- R1: A word is treated as an XYZ word when the three input words just before it were 3FF, 000 and 000, in that order. `trs_mark` is high for exactly the output cycle that carries that word, in every mode.
- R2: Every input word appears on `vid_out` exactly 4 clock cycles after it is sampled. Words that are not XYZ words are never altered.
- R3: When insertion is active (`keep_rx_flags` = 0 and `insert_en` = 1), bit 8 (F) of the output XYZ word equals `fld_in` as sampled with the XYZ input word.
- R4: When insertion is active, bit 7 (V) of the output XYZ word equals `vblank_in` as sampled with the XYZ input word.
- R5: When insertion is active and `h_follows_rx` = 0, bit 6 (H) of the output XYZ word equals bit 6 of the received XYZ word. An EAV therefore keeps H = 1 and an SAV keeps H = 0, and `hblank_in` has no effect.
- R6: When insertion is active and `h_follows_rx` = 1, bit 6 (H) of the output XYZ word equals `hblank_in` as sampled with the XYZ input word.
- R7: A rewritten XYZ word has bit 9 = 1 and bits 1..0 = 0. Its protection bits are bit 5 = V^H, bit 4 = F^H, bit 3 = F^V and bit 2 = F^V^H.
- R8: When `keep_rx_flags` = 1, the XYZ word leaves unchanged and `fld_in`, `vblank_in`, `hblank_in` and `h_follows_rx` have no effect on the output.
- R9: When `insert_en` = 0, the XYZ word leaves unchanged.
- R10: While and right after synchronous reset (`rst` high), `vid_out` is 000 and `trs_mark` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_in | input | 10 | Incoming video word |
| fld_in | input | 1 | Field timing input, high during the second field |
| vblank_in | input | 1 | Vertical blanking timing input |
| hblank_in | input | 1 | Horizontal blanking timing input |
| keep_rx_flags | input | 1 | 1: leave received flags untouched, 0: use the timing inputs |
| insert_en | input | 1 | Processing enable for flag insertion |
| h_follows_rx | input | 1 | H convention select: 0 keeps the received EAV/SAV H bit, 1 copies `hblank_in` |
| vid_out | output | 10 | Video word with rewritten XYZ words, 4 cycles later |
| trs_mark | output | 1 | High for the cycle carrying an XYZ word |

## Verification
Suppose the delay taps held a wrong word. The damage shows on `vid_out` four cycles after the faulty input. It also shows as a missing or spurious `trs_mark`, because the preamble is matched against those same taps. A wrong insert or hold decision is visible only on the XYZ word itself. For that reason every combination of mode, enable, H convention, timing inputs and received H bit is swept over a full sequence. Each output word is then compared against an arithmetic model at the exact cycle it leaves the block.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int VW = 10;
    typedef logic [VW-1:0] vword_t;

    localparam vword_t PRE_HIGH = 10'h3FF;
    localparam vword_t PRE_LOW  = 10'h000;

    // Field positions in the status word; downstream receivers decode these
    localparam int BIT_ONE = 9;
    localparam int BIT_F   = 8;
    localparam int BIT_V   = 7;
    localparam int BIT_H   = 6;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } fvh_t;

    typedef struct packed {
        vword_t word;
        logic   mark;
    } stage_t;

    function automatic vword_t make_xyz(fvh_t b);
        vword_t x;
        x          = '0;
        x[BIT_ONE] = 1'b1;
        x[BIT_F]   = b.f;
        x[BIT_V]   = b.v;
        x[BIT_H]   = b.h;
        x[5]       = b.v ^ b.h;
        x[4]       = b.f ^ b.h;
        x[3]       = b.f ^ b.v;
        x[2]       = b.f ^ b.v ^ b.h;
        return x;
    endfunction

endpackage

// File: rtl/trs_preamble_match.sv
module trs_preamble_match
    import trs_pkg::*;
(
    input  vword_t back1,
    input  vword_t back2,
    input  vword_t back3,
    output logic   hit
);

    // Current input word is a status word when the prior three form the preamble
    always_comb begin
        hit = (back1 == PRE_LOW) && (back2 == PRE_LOW) && (back3 == PRE_HIGH);
    end

endmodule

// File: rtl/trs_xyz_rewrite.sv
module trs_xyz_rewrite
    import trs_pkg::*;
(
    input  vword_t rx_word,
    input  logic   hit,
    input  logic   do_insert,
    input  logic   h_follows_rx,
    input  logic   fld_in,
    input  logic   vblank_in,
    input  logic   hblank_in,
    output vword_t word_out
);

    fvh_t sel;

    always_comb begin
        sel.f = fld_in;
        sel.v = vblank_in;
        sel.h = h_follows_rx ? hblank_in : rx_word[BIT_H];
        word_out = (hit && do_insert) ? make_xyz(sel) : rx_word;
    end

endmodule

// File: rtl/trs_delay_line.sv
module trs_delay_line
    import trs_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  stage_t din,
    output stage_t taps [DEPTH]
);

    stage_t regs [DEPTH];

    genvar k;
    generate
        for (k = 0; k < DEPTH; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[k] <= '0;
                end else if (k == 0) begin
                    regs[k] <= din;
                end else begin
                    regs[k] <= regs[(k == 0) ? 0 : k - 1];
                end
            end
            assign taps[k] = regs[k];
        end
    endgenerate

endmodule

// File: rtl/trs_flag_inserter.sv
module trs_flag_inserter
    import trs_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [9:0] vid_in,
    input  logic       fld_in,
    input  logic       vblank_in,
    input  logic       hblank_in,
    input  logic       keep_rx_flags,
    input  logic       insert_en,
    input  logic       h_follows_rx,
    output logic [9:0] vid_out,
    output logic       trs_mark
);

    // Preamble matching needs three words of history from the delay taps
    localparam int DEPTH = (LATENCY < 3) ? 3 : LATENCY;

    stage_t taps [DEPTH];
    stage_t entry;
    logic   hit;
    logic   do_insert;
    vword_t new_word;

    assign do_insert = insert_en && !keep_rx_flags;

    trs_preamble_match u_match (
        .back1 (taps[0].word),
        .back2 (taps[1].word),
        .back3 (taps[2].word),
        .hit   (hit)
    );

    trs_xyz_rewrite u_rewrite (
        .rx_word      (vid_in),
        .hit          (hit),
        .do_insert    (do_insert),
        .h_follows_rx (h_follows_rx),
        .fld_in       (fld_in),
        .vblank_in    (vblank_in),
        .hblank_in    (hblank_in),
        .word_out     (new_word)
    );

    always_comb begin
        entry.word = new_word;
        entry.mark = hit;
    end

    trs_delay_line #(.DEPTH(DEPTH)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (entry),
        .taps (taps)
    );

    assign vid_out  = taps[DEPTH-1].word;
    assign trs_mark = taps[DEPTH-1].mark;

    // One cycle after reset release, the first tap holds a real sample
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    assert_mark_single_R1: assert property (@(posedge clk) disable iff (rst)
        taps[0].mark |=> !taps[0].mark);

    assert_plain_unchanged_R2: assert property (@(posedge clk) disable iff (rst)
        (live_q && !taps[0].mark) |-> taps[0].word == $past(vid_in));

    assert_field_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && taps[0].mark && $past(insert_en && !keep_rx_flags))
        |-> taps[0].word[BIT_F] == $past(fld_in));

    assert_vblank_bit_R4: assert property (@(posedge clk) disable iff (rst)
        (live_q && taps[0].mark && $past(insert_en && !keep_rx_flags))
        |-> taps[0].word[BIT_V] == $past(vblank_in));

    assert_h_from_rx_R5: assert property (@(posedge clk) disable iff (rst)
        (live_q && taps[0].mark && $past(insert_en && !keep_rx_flags && !h_follows_rx))
        |-> taps[0].word[BIT_H] == $past(vid_in[BIT_H]));

    assert_h_from_pin_R6: assert property (@(posedge clk) disable iff (rst)
        (live_q && taps[0].mark && $past(insert_en && !keep_rx_flags && h_follows_rx))
        |-> taps[0].word[BIT_H] == $past(hblank_in));

    assert_protect_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (live_q && taps[0].mark && $past(insert_en && !keep_rx_flags))
        |-> (taps[0].word[9] && taps[0].word[1:0] == 2'b00
             && taps[0].word[2] == (taps[0].word[3] ^ taps[0].word[6])
             && taps[0].word[5] == (taps[0].word[7] ^ taps[0].word[6])
             && taps[0].word[4] == (taps[0].word[8] ^ taps[0].word[6])));

    assert_keep_rx_R8: assert property (@(posedge clk) disable iff (rst)
        (live_q && taps[0].mark && $past(keep_rx_flags))
        |-> taps[0].word == $past(vid_in));

    assert_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        (live_q && taps[0].mark && $past(!insert_en))
        |-> taps[0].word == $past(vid_in));

endmodule

// File: tb/trs_flag_inserter_tb.sv
module trs_flag_inserter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] vid_in = '0;
    logic       fld_in = 1'b0, vblank_in = 1'b0, hblank_in = 1'b0;
    logic       keep_rx_flags = 1'b0, insert_en = 1'b0, h_follows_rx = 1'b0;
    logic [9:0] vid_out;
    logic       trs_mark;

    always #4 clk = ~clk;

    trs_flag_inserter dut_i (
        .clk           (clk),
        .rst           (rst),
        .vid_in        (vid_in),
        .fld_in        (fld_in),
        .vblank_in     (vblank_in),
        .hblank_in     (hblank_in),
        .keep_rx_flags (keep_rx_flags),
        .insert_en     (insert_en),
        .h_follows_rx  (h_follows_rx),
        .vid_out       (vid_out),
        .trs_mark      (trs_mark)
    );

    typedef struct {
        logic [9:0] word;
        logic       mark;
        logic       ins;
        logic       cfg;
        logic       keep;
    } exp_t;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    exp_t e [4];
    logic [9:0] h1 = '0, h2 = '0, h3 = '0;

    task automatic chk(string req, logic [9:0] act, logic [9:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step(logic [9:0] w, logic f, logic v, logic h,
                        logic keep, logic en, logic cfg);
        exp_t n;
        logic is_trs;
        logic hb;
        is_trs = (h1 == 10'h000) && (h2 == 10'h000) && (h3 == 10'h3FF);
        n.mark = is_trs;
        n.ins  = is_trs && en && !keep;
        n.cfg  = cfg;
        n.keep = keep;
        hb     = cfg ? h : w[6];
        if (n.ins)
            n.word = {1'b1, f, v, hb, v ^ hb, f ^ hb, f ^ v, f ^ v ^ hb, 2'b00};
        else
            n.word = w;
        h3 = h2; h2 = h1; h1 = w;
        e[3] = e[2]; e[2] = e[1]; e[1] = e[0]; e[0] = n;
        vid_in = w; fld_in = f; vblank_in = v; hblank_in = h;
        keep_rx_flags = keep; insert_en = en; h_follows_rx = cfg;
        @(negedge clk);
        chk("R1 marker", {9'd0, trs_mark}, {9'd0, e[3].mark});
        if (!e[3].mark) begin
            chk("R2 word", vid_out, e[3].word);
        end else if (e[3].ins) begin
            chk("R3 F bit", {9'd0, vid_out[8]}, {9'd0, e[3].word[8]});
            chk("R4 V bit", {9'd0, vid_out[7]}, {9'd0, e[3].word[7]});
            if (e[3].cfg) chk("R6 H bit", {9'd0, vid_out[6]}, {9'd0, e[3].word[6]});
            else          chk("R5 H bit", {9'd0, vid_out[6]}, {9'd0, e[3].word[6]});
            chk("R7 fixed and protection", vid_out & 10'h23F, e[3].word & 10'h23F);
        end else if (e[3].keep) begin
            chk("R8 kept word", vid_out, e[3].word);
        end else begin
            chk("R9 disabled word", vid_out, e[3].word);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) e[i] = '{word: '0, mark: 1'b0, ins: 1'b0, cfg: 1'b0, keep: 1'b0};
        repeat (3) @(negedge clk);
        chk("R10 reset word", vid_out, 10'h000);
        chk("R10 reset mark", {9'd0, trs_mark}, 10'h000);
        rst = 1'b0;
        chk("R10 word after reset", vid_out, 10'h000);
        for (int c = 0; c < 128; c++) begin
            logic keep, en, cfg, f, v, h, rxh;
            logic [9:0] rx;
            keep = c[6]; en = c[5]; cfg = c[4];
            f = c[3]; v = c[2]; h = c[1]; rxh = c[0];
            rx = {1'b1, ~f, ~v, rxh, 4'(c * 3), 2'(c)};
            step(10'(c * 113 + 7) | 10'h004, f, v, h, keep, en, cfg);
            step(10'h3FF, ~f, ~v, ~h, keep, en, cfg);
            step(10'h000, ~f, v, ~h, keep, en, cfg);
            step(10'h000, f, ~v, h, keep, en, cfg);
            step(rx, f, v, h, keep, en, cfg);
            step(10'(c * 29 + 300) | 10'h008, ~f, ~v, ~h, keep, en, cfg);
            // near-miss preamble: last word nonzero, no marker expected (R1)
            step(10'h3FF, f, v, h, keep, en, cfg);
            step(10'h000, f, v, h, keep, en, cfg);
            step(10'h001, f, v, h, keep, en, cfg);
            step(rx, f, v, h, keep, en, cfg);
        end
        for (int i = 0; i < 4; i++) step(10'h155, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule